// File: doc/BRIEF.md
# Split-Carry Low-Activity Integrate-and-Dump Accumulator

This block integrates signed 3-bit correlator products into a 16-bit running total, one product per accepted sample, and releases the total when a dump strobe arrives. Dumps nominally come about once per millisecond. A correlator channel instantiates six copies, one per arm.

The adder is kept small to save power. Only a 3-bit adder and a 3-bit register hold the least significant part of the total. The upper 13 bits live in an up/down counter. That counter moves by one step only when the small adder produces a carry or a borrow, so most upper bits stay still from sample to sample. On a dump, the counter and the low register are joined into one 16-bit word. The word is registered to the output together with a one-cycle valid pulse, and both halves restart from zero.

Top module: `split_carry_accum`

## Requirements
- R1: After a synchronous active-low reset, `acc_out` is 0 and `acc_valid` is 0, and a dump with no accepted samples yields 0.
- R2: A sample is accepted only when `smp_valid` is 1 and is read as two's complement in the range -4..+3. When `smp_valid` is 0, the value on `smp_data` has no effect on any later result.
- R3: A dump result equals the sum of all accepted samples since the previous dump, modulo 2^16. The low register supplies bits [2:0] and the counter supplies bits [15:3].
- R4: Per accepted sample, the upper 13-bit part changes by at most one. It goes up by one when the low addition carries past 7 and down by one when it falls below 0. For example, +3,+3,+3 gives 0x0009 and a single -1 gives 0xFFFF.
- R5: A dump with `smp_valid` low outputs the total of the samples accepted before it.
- R6: A sample accepted in the same cycle as a dump is included in that dump's result. Both halves of the sum are zero in the cycle after a dump, so the next period starts from zero.
- R7: A total beyond the 16-bit range wraps modulo 2^16, and no flag is raised.
- R8: `acc_valid` is 1 for exactly the one cycle after each cycle in which `dump` is 1, and 0 otherwise.
- R9: `acc_out` keeps its value in every cycle that follows a cycle without a dump.
- R10: The upper counter holds still in every cycle without an accepted sample or a dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` for this cycle |
| smp_data | input | 3 | Signed product to accumulate |
| dump | input | 1 | Release the total and restart |
| acc_out | output | 16 | Registered dumped total |
| acc_valid | output | 1 | One-cycle pulse marking a new `acc_out` |

## Verification
The bench goes after carry and borrow crossings at the low/high boundary:
- Runs of +3 and of -4 show whether the counter steps the wrong way or misses a step. A design with either fault puts a wrong value in bits [15:3].
- The bench sweeps every pair of input values. This includes negative inputs from a low register at zero, where a missing sign extension would count up instead of down.
- A dump that coincides with a valid sample must include that sample and leave the next period at zero. A design that drops the sample, or clears too late, gives an off-by-one-sample result in either period.
- Long same-sign runs cross the 16-bit boundary and must wrap. Garbage on `smp_data` while `smp_valid` is low must leave no trace in the result.

// File: rtl/sca_pkg.sv
// Package: shared widths and the carry-step encoding used between the
// low accumulator and the high counter of the split-carry accumulator.
package sca_pkg;
    localparam int SCA_IN_W   = 3;   // signed sample width
    localparam int SCA_LOW_W  = 3;   // low register width
    localparam int SCA_HIGH_W = 13;  // high counter width

    // Step request from the low adder to the high counter.
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DN   = 2'b11
    } step_e;
endpackage

// File: rtl/sca_low_accum.sv
// Module: sca_low_accum
// Holds the low LOW_W bits of the running total. Each accepted signed
// sample is added after sign extension. The two bits above the low field
// of the widened sum encode the step for the high counter (-1, 0, +1).
// Assumes IN_W <= LOW_W + 1, so one sample never needs more than one step.
module sca_low_accum
    import sca_pkg::*;
#(
    parameter int IN_W  = SCA_IN_W,
    parameter int LOW_W = SCA_LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [IN_W-1:0]  smp_data,
    input  logic             clr,
    output logic [LOW_W-1:0] lo,
    output logic [LOW_W-1:0] lo_next,
    output step_e            step
);
    localparam int EXT_W = LOW_W + 2;

    logic [EXT_W-1:0] smp_ext;
    logic [EXT_W-1:0] wide_sum;
    logic [1:0]       top_bits;

    // Widen the sample and the register, then add them.
    always_comb begin
        smp_ext  = {{(EXT_W-IN_W){smp_data[IN_W-1]}}, smp_data};
        wide_sum = {2'b00, lo} + smp_ext;
        top_bits = wide_sum[EXT_W-1 -: 2];
    end

    // Choose the next low value and the step request for the counter.
    always_comb begin
        lo_next = lo;
        step    = STEP_NONE;
        if (smp_valid) begin
            lo_next = wide_sum[LOW_W-1:0];
            if (top_bits == 2'b01) begin
                step = STEP_UP;
            end else if (top_bits == 2'b11) begin
                step = STEP_DN;
            end
        end
    end

    // Low register: clears on reset and on a dump.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo <= '0;
        end else begin
            lo <= lo_next;
        end
    end

    AST_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !clr) |=> $stable(lo)); // R2
endmodule

// File: rtl/sca_high_counter.sv
// Module: sca_high_counter
// Holds the upper HIGH_W bits of the running total as an up/down counter.
// It moves only on a step request, so its bits toggle rarely.
// Assumes step is STEP_NONE whenever no sample is accepted.
module sca_high_counter
    import sca_pkg::*;
#(
    parameter int HIGH_W = SCA_HIGH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              clr,
    output logic [HIGH_W-1:0] hi,
    output logic [HIGH_W-1:0] hi_next
);
    // Work out the counter value after this cycle's step.
    always_comb begin
        case (step)
            STEP_UP: hi_next = hi + 1'b1;
            STEP_DN: hi_next = hi - 1'b1;
            default: hi_next = hi;
        endcase
    end

    // Counter register: clears on reset and on a dump.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi <= '0;
        end else begin
            hi <= hi_next;
        end
    end

    AST_HI_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((hi == $past(hi)) || (hi == $past(hi) + 1'b1)
                    || (hi == $past(hi) - 1'b1))); // R4
    AST_HI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step == STEP_NONE) |=> $stable(hi)); // R10
endmodule

// File: rtl/sca_dump_reg.sv
// Module: sca_dump_reg
// Captures the joined total on a dump and flags it for one cycle.
// Holds the captured value until the next dump.
module sca_dump_reg #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dump,
    input  logic [OUT_W-1:0] total,
    output logic [OUT_W-1:0] acc_out,
    output logic             acc_valid
);
    // Output register and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out   <= '0;
            acc_valid <= 1'b0;
        end else begin
            acc_valid <= dump;
            if (dump) begin
                acc_out <= total;
            end
        end
    end

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> acc_valid); // R8
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> !acc_valid); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(acc_out)); // R9
endmodule

// File: rtl/split_carry_accum.sv
// Module: split_carry_accum (top)
// Integrate-and-dump accumulator. The sum is split into a small adder for
// the low bits and a carry-driven counter for the high bits. A dump
// releases {counter, low} including any sample accepted in the same cycle,
// then restarts from zero. Overflow wraps silently.
module split_carry_accum
    import sca_pkg::*;
#(
    parameter int IN_W   = SCA_IN_W,
    parameter int LOW_W  = SCA_LOW_W,
    parameter int HIGH_W = SCA_HIGH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [IN_W-1:0]          smp_data,
    input  logic                     dump,
    output logic [HIGH_W+LOW_W-1:0]  acc_out,
    output logic                     acc_valid
);
    localparam int SUM_W = HIGH_W + LOW_W;

    logic [LOW_W-1:0]  lo_q;
    logic [LOW_W-1:0]  lo_d;
    logic [HIGH_W-1:0] hi_q;
    logic [HIGH_W-1:0] hi_d;
    logic [SUM_W-1:0]  joined;
    step_e             carry_step;

    sca_low_accum #(.IN_W(IN_W), .LOW_W(LOW_W)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .clr       (dump),
        .lo        (lo_q),
        .lo_next   (lo_d),
        .step      (carry_step)
    );

    sca_high_counter #(.HIGH_W(HIGH_W)) u_high (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (carry_step),
        .clr     (dump),
        .hi      (hi_q),
        .hi_next (hi_d)
    );

    // Join the post-sample halves so a coincident sample is included.
    always_comb begin
        joined = {hi_d, lo_d};
    end

    sca_dump_reg #(.OUT_W(SUM_W)) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .dump      (dump),
        .total     (joined),
        .acc_out   (acc_out),
        .acc_valid (acc_valid)
    );

    AST_CLEAR_ON_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> (hi_q == '0 && lo_q == '0)); // R6
endmodule

// File: tb/split_carry_accum_test.sv
// Self-checking bench: a plain 16-bit reference sum, with exhaustive
// single-value and pair sweeps, carry/borrow, wrap and random phases.
module split_carry_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_data = 3'd0;
    logic        dump = 1'b0;
    logic [15:0] acc_out;
    logic        acc_valid;

    int checks = 0;
    int bad = 0;
    logic [15:0] ref_sum = 16'd0;
    logic [15:0] last_out = 16'd0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    split_carry_accum uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_data(smp_data), .dump(dump),
        .acc_out(acc_out), .acc_valid(acc_valid)
    );

    task automatic chk(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the reference, check outputs after the edge.
    task automatic cyc(input string tag, input bit v, input logic [2:0] s,
                       input bit d);
        logic [15:0] exp;
        smp_valid = v;
        smp_data  = s;
        dump      = d;
        if (v) ref_sum = ref_sum + {{13{s[2]}}, s};
        exp = ref_sum;
        if (d) ref_sum = 16'd0;
        @(posedge clk);
        @(negedge clk);
        if (d) begin
            chk("R8", {15'd0, acc_valid}, 16'd1);
            chk(tag, acc_out, exp);
            last_out = exp;
        end else begin
            chk("R8", {15'd0, acc_valid}, 16'd0);
            chk("R9", acc_out, last_out);
        end
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 150000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cnt);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", acc_out, 16'd0);
        chk("R1", {15'd0, acc_valid}, 16'd0);
        rst_n = 1'b1;
        cyc("R1", 1'b0, 3'd0, 1'b1);

        // Every single value, dumped alone (R5) and coincident (R6).
        for (int a = 0; a < 8; a++) begin
            cyc("R5", 1'b1, 3'(a), 1'b0);
            cyc("R5", 1'b0, 3'd5, 1'b1);
            cyc("R6", 1'b1, 3'(a), 1'b1);
            cyc("R6", 1'b0, 3'd0, 1'b1);
        end

        // Every pair of values: carry and borrow paths (R3, R4).
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                cyc("R3", 1'b1, 3'(a), 1'b0);
                cyc("R3", 1'b1, 3'(b), 1'b0);
                cyc("R3", 1'b0, 3'd0, 1'b1);
            end
        end

        // Named carry and borrow cases (R4).
        cyc("R4", 1'b1, 3'd3, 1'b0);
        cyc("R4", 1'b1, 3'd3, 1'b0);
        cyc("R4", 1'b1, 3'd3, 1'b1);
        chk("R4", acc_out, 16'h0009);
        cyc("R4", 1'b1, 3'b111, 1'b1);
        chk("R4", acc_out, 16'hFFFF);

        // Invalid garbage between samples leaves no trace (R2, R10).
        cyc("R2", 1'b1, 3'd1, 1'b0);
        for (int k = 0; k < 8; k++) cyc("R2", 1'b0, 3'(k), 1'b0);
        cyc("R2", 1'b1, 3'b111, 1'b0);
        cyc("R10", 1'b0, 3'd3, 1'b1);
        chk("R10", acc_out, 16'h0000);

        // Positive wrap: 30000 * 3 = 90000 -> 24464 (R7).
        for (int k = 0; k < 30000; k++) cyc("R7", 1'b1, 3'd3, 1'b0);
        cyc("R7", 1'b0, 3'd0, 1'b1);
        chk("R7", acc_out, 16'd24464);
        // Negative wrap: 20000 * -4 = -80000 -> 51072 (R7).
        for (int k = 0; k < 20000; k++) cyc("R7", 1'b1, 3'b100, 1'b0);
        cyc("R7", 1'b0, 3'd0, 1'b1);
        chk("R7", acc_out, 16'd51072);

        // Random samples and dumps against the reference (R3, R6).
        for (int k = 0; k < 20000; k++) begin
            cyc("R3", bit'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                bit'($urandom_range(0, 40) == 0));
        end
        cyc("R5", 1'b0, 3'd0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule